// File: doc/BRIEF.md
# Frame-Sync Serial ADC Readout Controller

This block sits on the host side of a multi-channel sampling converter and pulls the finished conversion results across a serial link that is framed by an active-low sync line. When a start request arrives together with a mask of the channel pairs that were converted, the controller lowers the frame sync while its serial clock is idling high. It then toggles the clock and shifts in one serial data line, capturing a bit on every falling edge. It stops exactly at the end of the highest converted pair, so it never clocks out stale results left in the buffer of a pair that was not converted.

Each pair carries two 16-bit channel words, sent MSB first, with the pairs in the fixed order A, B, C. The serial clock half period is a run-time divide of the system clock. When the frame closes, the results of the converted pairs are loaded into the parallel output register in one cycle, together with a single-cycle done pulse. The frame sync then stays high for at least one full serial clock period.

The controller moves through six named states. IDLE leaves both lines high and goes to LEAD on an accepted start. LEAD holds sync low and the clock high for one half period, then goes to LOW with the first falling edge and sample. LOW goes to HIGH after a half period. HIGH goes back to LOW with the next falling edge and sample, or goes to GAP_A once the last bit has been taken, raising sync and committing the words. GAP_A goes to GAP_B after a half period, and GAP_B goes back to IDLE after a half period.

Top module: `fsync_adc_reader`

## Requirements
- R1: After reset, `adc_fs_n` and `adc_sclk` are high, `done` is low and `data_out` is all zero.
- R2: `adc_fs_n` only falls while `adc_sclk` is high and was high in the previous cycle, so the first clock edge inside a frame is a falling edge.
- R3: A data bit is captured at each falling edge of `adc_sclk`. The bits form 16-bit words, MSB first, in the order A0, A1, B0, B1, C0, C1. Word k is placed at `data_out[16*k +: 16]`.
- R4: `pair_mask` bit 0 selects pair A, bit 1 selects pair B and bit 2 selects pair C. A frame issues 32 × (index of the highest set bit + 1) falling edges: 32 for A alone, 64 when B is the highest set bit, and 96 whenever C is set.
- R5: At the end of a frame, only the words of pairs whose mask bit is set are updated. All other words keep their value, including the words of a pair that was clocked through but not selected.
- R6: Each half period of `adc_sclk` lasts max(`half_div`, 2) system clocks, with `half_div` taken when the start is accepted.
- R7: `adc_sclk` is high whenever `adc_fs_n` is high. `adc_fs_n` rises only after the last falling edge, with the clock already high. It then stays high for at least two half periods before the next frame opens.
- R8: `done` is a one-cycle pulse, issued only while `adc_fs_n` is high. `data_out` changes only in the cycle in which `done` is high.
- R9: `start` is ignored while a frame or its trailing gap is in progress, and it is ignored when `pair_mask` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Readout request, sampled in IDLE |
| pair_mask | input | 3 | Converted pairs; bit 0 = A, bit 1 = B, bit 2 = C |
| half_div | input | 8 | Serial clock half period in system clocks (minimum 2 applied) |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_fs_n | output | 1 | Active-low frame sync |
| adc_sclk | output | 1 | Serial clock, idles high |
| data_out | output | 96 | Six 16-bit channel words, word k at bits 16k+15..16k |
| done | output | 1 | One-cycle pulse when `data_out` is updated |

## Verification
The readout is driven with every non-zero pair mask. A alone, A with B, and each mask that includes C are the patterns that separate the 32-, 64- and 96-edge frame lengths. Masks with a gap, such as A and C, show whether a pair that was clocked through but not selected is wrongly written. Random channel words expose bit-order, word-order and one-bit shift errors. Divider values 0, 1 and above 2 separate the clamped half period from the programmed one. A start held across the end of a frame shows whether the gap is kept, and starts raised mid-frame or with an empty mask show whether a request is wrongly accepted.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_GAP_A,
        ST_GAP_B
    } fsr_state_e;

endpackage

// File: rtl/fsr_phase_timer.sv
module fsr_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] limit,
    output logic             expire
);
    logic [DIV_W-1:0] cnt_q;

    assign expire = run && (cnt_q == limit - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/fsr_bit_shifter.sv
module fsr_bit_shifter #(
    parameter int TOTAL_W = 96,
    parameter int CNT_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               sample,
    input  logic               sdo,
    output logic [TOTAL_W-1:0] bits,
    output logic [CNT_W-1:0]   count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits  <= '0;
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (sample) begin
            bits  <= {bits[TOTAL_W-2:0], sdo};
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/fsr_word_bank.sv
module fsr_word_bank #(
    parameter int WORD_W      = 16,
    parameter int CH_PER_PAIR = 2,
    parameter int NUM_PAIRS   = 3,
    parameter int NW_W        = 3,
    localparam int NUM_WORDS  = CH_PER_PAIR * NUM_PAIRS,
    localparam int TOTAL_W    = NUM_WORDS * WORD_W,
    localparam int IDX_W      = $clog2(TOTAL_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit,
    input  logic [NUM_PAIRS-1:0] pair_mask,
    input  logic [NW_W-1:0]      nwords,
    input  logic [TOTAL_W-1:0]   bits,
    output logic [TOTAL_W-1:0]   words
);
    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        localparam int PAIR = k / CH_PER_PAIR;
        logic [WORD_W-1:0] w_q;
        logic [NW_W-1:0]   pos;
        logic [IDX_W-1:0]  base;
        logic              in_frame;

        assign in_frame = (NW_W'(k) < nwords);
        assign pos      = in_frame ? (nwords - NW_W'(k + 1)) : '0;
        assign base     = IDX_W'(int'(pos) * WORD_W);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                w_q <= '0;
            end else if (commit && pair_mask[PAIR] && in_frame) begin
                w_q <= bits[base +: WORD_W];
            end
        end

        assign words[k*WORD_W +: WORD_W] = w_q;
    end
endmodule

// File: rtl/fsync_adc_reader.sv
module fsync_adc_reader #(
    parameter int WORD_W      = 16,
    parameter int CH_PER_PAIR = 2,
    parameter int NUM_PAIRS   = 3,
    parameter int DIV_W       = 8,
    parameter int MIN_HALF    = 2,
    localparam int NUM_WORDS  = CH_PER_PAIR * NUM_PAIRS,
    localparam int TOTAL_W    = NUM_WORDS * WORD_W,
    localparam int PAIR_BITS  = CH_PER_PAIR * WORD_W,
    localparam int CNT_W      = $clog2(TOTAL_W + 1),
    localparam int NW_W       = $clog2(NUM_WORDS + 1),
    localparam int PC_W       = $clog2(NUM_PAIRS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [NUM_PAIRS-1:0] pair_mask,
    input  logic [DIV_W-1:0]     half_div,
    input  logic                 adc_sdo,
    output logic                 adc_fs_n,
    output logic                 adc_sclk,
    output logic [TOTAL_W-1:0]   data_out,
    output logic                 done
);
    import fsr_pkg::*;

    fsr_state_e state_q, state_d;

    logic [NUM_PAIRS-1:0] mask_q;
    logic [DIV_W-1:0]     lim_q, lim_d;
    logic [CNT_W-1:0]     goal_q, goal_d;
    logic [NW_W-1:0]      nw_q, nw_d;
    logic [PC_W-1:0]      top_pairs;
    logic                 fs_q, sclk_q, done_q;
    logic                 accept, expire, sample, commit, last_bit;
    logic [TOTAL_W-1:0]   bits;
    logic [CNT_W-1:0]     count;

    // frame length follows the highest pair that was converted
    always_comb begin
        top_pairs = '0;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            if (pair_mask[p]) top_pairs = PC_W'(p + 1);
        end
        goal_d = CNT_W'(int'(top_pairs) * PAIR_BITS);
        nw_d   = NW_W'(int'(top_pairs) * CH_PER_PAIR);
        lim_d  = (half_div < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : half_div;
    end

    assign accept   = (state_q == ST_IDLE) && start && (|pair_mask);
    assign last_bit = (count == goal_q);
    assign sample   = expire && ((state_q == ST_LEAD) ||
                                 ((state_q == ST_HIGH) && !last_bit));
    assign commit   = expire && (state_q == ST_HIGH) && last_bit;

    fsr_phase_timer #(.DIV_W(DIV_W)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q != ST_IDLE),
        .limit  (lim_q),
        .expire (expire)
    );

    fsr_bit_shifter #(.TOTAL_W(TOTAL_W), .CNT_W(CNT_W)) shift_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .sample (sample),
        .sdo    (adc_sdo),
        .bits   (bits),
        .count  (count)
    );

    fsr_word_bank #(
        .WORD_W      (WORD_W),
        .CH_PER_PAIR (CH_PER_PAIR),
        .NUM_PAIRS   (NUM_PAIRS),
        .NW_W        (NW_W)
    ) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .pair_mask (mask_q),
        .nwords    (nw_q),
        .bits      (bits),
        .words     (data_out)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_LEAD;
            ST_LEAD:  if (expire) state_d = ST_LOW;
            ST_LOW:   if (expire) state_d = ST_HIGH;
            ST_HIGH:  if (expire) state_d = last_bit ? ST_GAP_A : ST_LOW;
            ST_GAP_A: if (expire) state_d = ST_GAP_B;
            ST_GAP_B: if (expire) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // registered outputs and per-frame settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q   <= 1'b1;
            sclk_q <= 1'b1;
            done_q <= 1'b0;
            mask_q <= '0;
            lim_q  <= DIV_W'(MIN_HALF);
            goal_q <= '0;
            nw_q   <= '0;
        end else begin
            fs_q   <= (state_d == ST_IDLE) || (state_d == ST_GAP_A) ||
                      (state_d == ST_GAP_B);
            sclk_q <= (state_d != ST_LOW);
            done_q <= commit;
            if (accept) begin
                mask_q <= pair_mask;
                lim_q  <= lim_d;
                goal_q <= goal_d;
                nw_q   <= nw_d;
            end
        end
    end

    assign adc_fs_n = fs_q;
    assign adc_sclk = sclk_q;
    assign done     = done_q;
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
    parameter int TOTAL_W  = 96,
    parameter int MIN_HALF = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               adc_fs_n,
    input logic               adc_sclk,
    input logic [TOTAL_W-1:0] data_out,
    input logic               done
);
    logic [15:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         low_run <= '0;
        else if (!adc_sclk) low_run <= low_run + 1'b1;
        else                low_run <= '0;
    end

    assert_open_clock_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_fs_n) |-> (adc_sclk && $past(adc_sclk)));

    assert_idle_clock_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        adc_fs_n |-> adc_sclk);

    assert_close_clock_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_fs_n) |-> $past(adc_sclk));

    assert_min_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_sclk) |-> (low_run >= 16'(MIN_HALF)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_outside_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> adc_fs_n);

    assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_out) |-> done);
endmodule

bind fsync_adc_reader fsr_checker #(
    .TOTAL_W  (TOTAL_W),
    .MIN_HALF (MIN_HALF)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .adc_fs_n (adc_fs_n),
    .adc_sclk (adc_sclk),
    .data_out (data_out),
    .done     (done)
);

// File: tb/fsync_adc_reader_tb.sv
module fsync_adc_reader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  pair_mask = '0;
    logic [7:0]  half_div = 8'd2;
    logic        adc_sdo = 1'b0;
    logic        adc_fs_n;
    logic        adc_sclk;
    logic [95:0] data_out;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    fsync_adc_reader dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .pair_mask (pair_mask),
        .half_div  (half_div),
        .adc_sdo   (adc_sdo),
        .adc_fs_n  (adc_fs_n),
        .adc_sclk  (adc_sclk),
        .data_out  (data_out),
        .done      (done)
    );

    // converter model: first bit on frame open, next bit on each rising edge
    logic [95:0] adc_bits = '0;
    int          adc_pos  = 0;

    always @(negedge adc_fs_n) begin
        adc_pos = 0;
        adc_sdo = adc_bits[95];
    end

    always @(posedge adc_sclk) begin
        if (!adc_fs_n) begin
            adc_pos = adc_pos + 1;
            adc_sdo = (adc_pos < 96) ? adc_bits[95 - adc_pos] : 1'b0;
        end
    end

    // monitor, sampled away from the active edge
    int   fall_cnt = 0, low_cyc = 0, done_cnt = 0, bad_open = 0, fs_lows = 0;
    logic prev_sclk = 1'b1, prev_fs = 1'b1;

    always @(negedge clk) begin
        if (prev_sclk && !adc_sclk && !adc_fs_n) fall_cnt++;
        if (!adc_fs_n && !adc_sclk) low_cyc++;
        if (done) done_cnt++;
        if (prev_fs && !adc_fs_n) begin
            fs_lows++;
            if (!adc_sclk || !prev_sclk) bad_open++;
        end
        prev_sclk = adc_sclk;
        prev_fs   = adc_fs_n;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [95:0] act, input logic [95:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    logic [15:0] exp_w [6];

    function automatic logic [95:0] exp_vec();
        logic [95:0] v;
        for (int k = 0; k < 6; k++) v[k*16 +: 16] = exp_w[k];
        return v;
    endfunction

    function automatic int frame_bits(input logic [2:0] m);
        int hi = 0;
        for (int p = 0; p < 3; p++) if (m[p]) hi = p + 1;
        return hi * 32;
    endfunction

    function automatic int eff_div(input logic [7:0] d);
        return (d < 8'd2) ? 2 : int'(d);
    endfunction

    task automatic clear_mon();
        fall_cnt = 0; low_cyc = 0; done_cnt = 0; bad_open = 0; fs_lows = 0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    // one readout; poke = extra start mid-frame, chain = start held across the gap
    task automatic run_frame(input logic [2:0] m, input logic [7:0] d,
                             input bit poke, input bit chain);
        logic [15:0] nw [6];
        bit          seen;
        int          eff = eff_div(d);
        int          nb  = frame_bits(m);
        int          fs_hi;
        for (int k = 0; k < 6; k++) nw[k] = 16'($urandom);
        adc_bits  = {nw[0], nw[1], nw[2], nw[3], nw[4], nw[5]};
        pair_mask = m;
        half_div  = d;
        clear_mon();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (poke) begin
            repeat (7 * eff) @(negedge clk);
            pair_mask = 3'b111;
            half_div  = 8'd9;
            start     = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        wait_done(seen);
        check(seen, "R8", "done seen", 96'(seen), 96'd1);
        for (int k = 0; k < 6; k++) if (m[k/2]) exp_w[k] = nw[k];
        check(data_out === exp_vec(), "R3/R5", "words", data_out, exp_vec());
        check(fall_cnt == nb, "R4", "falling edges", 96'(fall_cnt), 96'(nb));
        check(low_cyc == nb * eff, "R6", "low cycles", 96'(low_cyc), 96'(nb * eff));
        check(bad_open == 0, "R2", "open with clock low", 96'(bad_open), 96'd0);
        if (chain) begin
            start = 1'b1;
            fs_hi = 0;
            for (int i = 0; i < 2000 && adc_fs_n; i++) begin
                fs_hi++;
                @(negedge clk);
            end
            start = 1'b0;
            check(fs_hi >= 2 * eff, "R7", "gap cycles", 96'(fs_hi), 96'(2 * eff));
            wait_done(seen);
            check(data_out === exp_vec(), "R3", "chained words", data_out, exp_vec());
        end
        repeat (2 * eff + 3) @(negedge clk);
        check(done_cnt == (chain ? 2 : 1), "R8", "done pulses",
              96'(done_cnt), 96'(chain ? 2 : 1));
        check(fs_lows == (chain ? 2 : 1), "R9", "frames opened",
              96'(fs_lows), 96'(chain ? 2 : 1));
        check(adc_fs_n && adc_sclk, "R7", "idle lines", {adc_fs_n, adc_sclk}, 96'd3);
    endtask

    initial begin
        int seed_set;
        seed_set = int'($urandom(32'h5EED_0042));
        for (int k = 0; k < 6; k++) exp_w[k] = '0;
        repeat (3) @(negedge clk);
        check(adc_fs_n && adc_sclk && !done, "R1", "reset lines",
              {adc_fs_n, adc_sclk, done}, 96'b110);
        check(data_out == '0, "R1", "reset words", data_out, 96'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        run_frame(3'b001, 8'd0, 0, 0);   // A only, clamped divider
        run_frame(3'b011, 8'd1, 0, 0);   // A/B, 64 edges
        run_frame(3'b111, 8'd3, 0, 0);   // all pairs, 96 edges
        run_frame(3'b101, 8'd2, 0, 0);   // B clocked through, not written (R5)
        run_frame(3'b100, 8'd2, 0, 0);   // C only
        run_frame(3'b011, 8'd4, 1, 0);   // start mid-frame ignored (R9)
        run_frame(3'b110, 8'd2, 0, 1);   // start held across gap (R7)

        // empty mask is ignored (R9)
        clear_mon();
        pair_mask = 3'b000;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (30) @(negedge clk);
        check(fs_lows == 0 && done_cnt == 0, "R9", "empty mask",
              96'(fs_lows + done_cnt), 96'd0);
        check(data_out === exp_vec(), "R9", "words after empty mask", data_out, exp_vec());

        // random frames
        for (int i = 0; i < 16; i++) begin
            logic [2:0] m;
            m = 3'($urandom_range(1, 7));
            run_frame(m, 8'($urandom_range(0, 5)), (($urandom & 3) == 0), 0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule